// File: doc/BRIEF.md
# Microstepping Step/Direction Indexer

This block turns step pulses into winding current settings for a two-winding bipolar stepper motor. It holds a phase position in a 128-entry electrical cycle. Each accepted rising edge on the step input moves that position forward or back by a stride. The stride is set by a 3-bit resolution code and ranges from full step down to 1/32 step. From the position the block produces a signed current percentage for each winding: winding A follows the sine of the phase angle and winding B follows the cosine. It also produces an active-low flag that marks the home position.

The drive controller uses the two percentages as targets for its current regulators. Three inputs gate the block. An active-low enable freezes the position and zeroes both targets. An active-low reset returns the position to home. A power-up input puts the block in a low-power state, which keeps the position but zeroes both targets. Step edges are refused for a programmable number of clock cycles after waking.

All inputs are plain levels sampled on the clock. They are assumed to be already synchronised. The outputs are plain levels with no handshake, because each output is a continuous target and not a stream of items.

Top module: `stepper_indexer`

## Requirements
- R1: A low-to-high transition of `step_i`, seen between two consecutive clock samples, moves the position exactly once. The new targets appear in the cycle after the edge that sampled the high level. Holding `step_i` high causes no further moves.
- R2: When `dir_i` is 1 at the accepting edge, the position index increases. When it is 0, the index decreases.
- R3: `mode_i` sets the stride in table entries. Codes 0, 1, 2, 3, 4 and 5 give strides of 32, 16, 8, 4, 2 and 1 (full, 1/2, 1/4, 1/8, 1/16 and 1/32 step). Codes 6 and 7 also give a stride of 1. The mode is sampled at the accepting edge.
- R4: The position index is an integer from 0 to 127 and wraps modulo 128 in both directions.
- R5: While driven, `coil_a` equals round(100·sin(2π·i/128)) and `coil_b` equals round(100·cos(2π·i/128)), where i is the position index. Both are 8-bit two's complement values. Every nonzero magnitude lies between 5 and 100.
- R6: While `en_n` is 1, step edges are ignored and both targets are 0. When `en_n` returns to 0, the targets of the unchanged position reappear.
- R7: While `rst_n` is 0, the index is 16, both targets are 0 and `home_n` is 0. After release, the targets are 71 and 71.
- R8: `home_n` is 0 exactly when the index is 16 (45°, where both windings are at 71%) and is 1 at every other index.
- R9: While `pwr_up` is 0, both targets are 0 and step edges are ignored. The position is kept. After `pwr_up` returns to 1, step edges sampled at the first `WAKE_CYC` clock edges are ignored. A step edge sampled at the next clock edge is accepted.
- R10: Changing `mode_i` without a step edge leaves the position and the targets unchanged. There is no re-homing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; sends the position to home |
| step_i | input | 1 | Step request; acted on at its rising edge |
| dir_i | input | 1 | Direction: 1 raises the index, 0 lowers it |
| mode_i | input | 3 | Resolution code (stride selector) |
| en_n | input | 1 | Active-low enable; when high, freezes the position and zeroes the targets |
| pwr_up | input | 1 | 1 = awake, 0 = low-power state |
| coil_a | output | 8 | Signed current target for winding A, in percent |
| coil_b | output | 8 | Signed current target for winding B, in percent |
| home_n | output | 1 | Active-low home flag |

## Verification
The case that needs care is a step edge that lands in the same clock cycle in which the wake lockout ends. The bench puts the device to sleep and then wakes it twice. The first time, the step edge is placed so that it is sampled at the last locked clock edge. The second time, it is placed at the first unlocked edge. In the first case the targets must still show the old position; in the second they must show the neighbouring table entry. A second coincidence arises when the enable input is high in the same cycle that a step edge is sampled. There the bench expects zero targets, and then the same position once the enable input returns to 0.

// File: rtl/ix_pkg.sv
package ix_pkg;
  localparam int FINE_LOG2 = 5;
  localparam int QTR       = 1 << FINE_LOG2;
  localparam int IDX_W     = FINE_LOG2 + 2;
  localparam int PCT_W     = 8;
  localparam int MODE_W    = 3;

  typedef logic [IDX_W-1:0]        idx_t;
  typedef logic signed [PCT_W-1:0] pct_t;

  localparam idx_t HOME_IDX = idx_t'(QTR / 2);

  // magnitude of 100*sin(k*90deg/QTR) for k in 0..QTR
  function automatic logic [6:0] qtr_mag(input logic [FINE_LOG2:0] k);
    logic [6:0] m;
    case (k)
      6'd0:  m = 7'd0;   6'd1:  m = 7'd5;   6'd2:  m = 7'd10;  6'd3:  m = 7'd15;
      6'd4:  m = 7'd20;  6'd5:  m = 7'd24;  6'd6:  m = 7'd29;  6'd7:  m = 7'd34;
      6'd8:  m = 7'd38;  6'd9:  m = 7'd43;  6'd10: m = 7'd47;  6'd11: m = 7'd51;
      6'd12: m = 7'd56;  6'd13: m = 7'd60;  6'd14: m = 7'd63;  6'd15: m = 7'd67;
      6'd16: m = 7'd71;  6'd17: m = 7'd74;  6'd18: m = 7'd77;  6'd19: m = 7'd80;
      6'd20: m = 7'd83;  6'd21: m = 7'd86;  6'd22: m = 7'd88;  6'd23: m = 7'd90;
      6'd24: m = 7'd92;  6'd25: m = 7'd94;  6'd26: m = 7'd96;  6'd27: m = 7'd97;
      6'd28: m = 7'd98;  6'd29: m = 7'd99;
      default: m = 7'd100;
    endcase
    return m;
  endfunction

  // signed sine percentage at a full-cycle index, folded from one quarter
  function automatic pct_t sin_pct(input idx_t i);
    logic [1:0]           quad;
    logic [FINE_LOG2-1:0] r;
    logic [FINE_LOG2:0]   k;
    pct_t                 p;
    quad = i[IDX_W-1 -: 2];
    r    = i[FINE_LOG2-1:0];
    k    = quad[0] ? ((FINE_LOG2+1)'(QTR) - {1'b0, r}) : {1'b0, r};
    p    = pct_t'({1'b0, qtr_mag(k)});
    return quad[1] ? -p : p;
  endfunction

  // table stride for a resolution code; codes past the finest clamp to 1
  function automatic idx_t stride_of(input logic [MODE_W-1:0] m);
    int sh;
    sh = (int'(m) > FINE_LOG2) ? FINE_LOG2 : int'(m);
    return idx_t'(QTR >> sh);
  endfunction
endpackage

// File: rtl/ix_edge.sv
module ix_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/ix_wake.sv
module ix_wake #(
  parameter int WAKE_CYC = 85000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_up,
  output logic locked_o
);
  localparam int CNT_W = $clog2(WAKE_CYC + 1);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (!pwr_up)        left_q <= CNT_W'(WAKE_CYC);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign locked_o = (left_q != '0);
endmodule

// File: rtl/ix_phase.sv
module ix_phase
  import ix_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              fwd,
  input  logic [MODE_W-1:0] mode,
  output idx_t              idx_q
);
  idx_t stride;

  assign stride = stride_of(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= HOME_IDX;
    else if (adv)  idx_q <= fwd ? (idx_q + stride) : (idx_q - stride);
  end
endmodule

// File: rtl/ix_coil.sv
module ix_coil
  import ix_pkg::*;
#(
  parameter int PHASE_OFS = 0
) (
  input  idx_t idx,
  input  logic drive,
  output pct_t pct
);
  localparam idx_t OFS = idx_t'(PHASE_OFS);

  idx_t ph;

  assign ph  = idx + OFS;
  assign pct = drive ? sin_pct(ph) : '0;
endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer
  import ix_pkg::*;
#(
  parameter int WAKE_CYC = 85000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_i,
  input  logic                    dir_i,
  input  logic [2:0]              mode_i,
  input  logic                    en_n,
  input  logic                    pwr_up,
  output logic signed [PCT_W-1:0] coil_a,
  output logic signed [PCT_W-1:0] coil_b,
  output logic                    home_n
);
  localparam int N_WIND = 2;

  logic rise;
  logic locked;
  logic accept;
  logic drive;
  idx_t idx_q;
  pct_t wind [N_WIND];

  ix_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (step_i),
    .rise_o (rise)
  );

  ix_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_up   (pwr_up),
    .locked_o (locked)
  );

  assign accept = rise & ~en_n & pwr_up & ~locked;
  assign drive  = rst_n & ~en_n & pwr_up;

  ix_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (accept),
    .fwd   (dir_i),
    .mode  (mode_i),
    .idx_q (idx_q)
  );

  // winding w is the sine shifted by w quarter cycles (A: sine, B: cosine)
  for (genvar w = 0; w < N_WIND; w++) begin : g_wind
    ix_coil #(.PHASE_OFS(w * QTR)) u_coil (
      .idx   (idx_q),
      .drive (drive),
      .pct   (wind[w])
    );
  end

  assign coil_a = wind[0];
  assign coil_b = wind[1];
  assign home_n = (idx_q != HOME_IDX);
endmodule

// File: rtl/stepper_indexer_chk.sv
module stepper_indexer_chk
  import ix_pkg::*;
#(
  parameter int WAKE_CYC = 85000
) (
  input logic clk,
  input logic rst_n,
  input logic step_i,
  input logic en_n,
  input logic pwr_up,
  input pct_t coil_a,
  input pct_t coil_b,
  input logic home_n,
  input idx_t idx
);
  int unsigned since_wake;
  int          sa, sb, mag_a, mag_b, sq_sum;
  logic        driven;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_wake <= WAKE_CYC;
    else if (!pwr_up)                    since_wake <= 0;
    else if (since_wake < WAKE_CYC)      since_wake <= since_wake + 1;
  end

  always_comb begin
    sa     = int'(coil_a);
    sb     = int'(coil_b);
    mag_a  = (sa < 0) ? -sa : sa;
    mag_b  = (sb < 0) ? -sb : sb;
    sq_sum = sa * sa + sb * sb;
    driven = rst_n && !en_n && pwr_up;
  end

  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !step_i |=> $stable(idx)); // R1
  AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) en_n |=> $stable(idx)); // R6
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) en_n |-> (coil_a == 0 && coil_b == 0)); // R6
  AST_HOME_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (!home_n && driven) |-> (coil_a == 71 && coil_b == 71)); // R8
  AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !pwr_up |=> $stable(idx)); // R9
  AST_WAKE_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (pwr_up && since_wake < WAKE_CYC) |=> $stable(idx)); // R9
  AST_MAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (mag_a == 0 || (mag_a >= 5 && mag_a <= 100)) && (mag_b == 0 || (mag_b >= 5 && mag_b <= 100))); // R5
  AST_QUAD_SUM: assert property (@(posedge clk) disable iff (!rst_n) driven |-> (sq_sum >= 9800 && sq_sum <= 10200)); // R5
endmodule

bind stepper_indexer stepper_indexer_chk #(.WAKE_CYC(WAKE_CYC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .step_i (step_i),
  .en_n   (en_n),
  .pwr_up (pwr_up),
  .coil_a (coil_a),
  .coil_b (coil_b),
  .home_n (home_n),
  .idx    (idx_q)
);

// File: tb/test_stepper_indexer.sv
module test_stepper_indexer;
  localparam int CLK_PER = 10;
  localparam int WAKE    = 12;
  localparam int HOME    = 16;
  localparam int WDOG    = 20000;

  logic              clk    = 1'b0;
  logic              rst_n  = 1'b1;
  logic              step_i = 1'b0;
  logic              dir_i  = 1'b0;
  logic [2:0]        mode_i = 3'd0;
  logic              en_n   = 1'b0;
  logic              pwr_up = 1'b1;
  logic signed [7:0] coil_a, coil_b;
  logic              home_n;

  int n_cmp = 0;
  int n_bad = 0;
  int m_idx = HOME;
  bit done  = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  stepper_indexer #(.WAKE_CYC(WAKE)) i_stepper_indexer (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i), .mode_i(mode_i),
    .en_n(en_n), .pwr_up(pwr_up), .coil_a(coil_a), .coil_b(coil_b), .home_n(home_n)
  );

  function automatic int pct_of(int i, bit use_cos);
    real ang, v;
    ang = 2.0 * 3.14159265358979 * i / 128.0;
    v   = 100.0 * (use_cos ? $cos(ang) : $sin(ang));
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int stride(int m);
    return (m >= 5) ? 1 : (32 >> m);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_pos(string req);
    chk(req, "coil_a", int'(coil_a), pct_of(m_idx, 1'b0));
    chk(req, "coil_b", int'(coil_b), pct_of(m_idx, 1'b1));
    chk(req, "home_n", int'(home_n), (m_idx == HOME) ? 0 : 1);
  endtask

  task automatic chk_off(string req);
    chk(req, "coil_a", int'(coil_a), 0);
    chk(req, "coil_b", int'(coil_b), 0);
  endtask

  task automatic do_step(bit d, int m, bit moves);
    @(negedge clk);
    dir_i = d; mode_i = 3'(m); step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    if (moves) m_idx = d ? (m_idx + stride(m)) % 128 : (m_idx - stride(m) + 128) % 128;
  endtask

  // step sampled at the n-th clock edge after waking
  task automatic wake_probe(int n, bit moves);
    @(negedge clk);
    pwr_up = 1'b0;
    repeat (3) @(negedge clk);
    chk_off("R9");
    pwr_up = 1'b1;
    repeat (n - 1) @(negedge clk);
    dir_i = 1'b1; mode_i = 3'd5; step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    if (moves) m_idx = (m_idx + 1) % 128;
    chk_pos("R9");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_off("R7");
    chk("R7", "home_n", int'(home_n), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pos("R7");
    chk("R7", "coil_a", int'(coil_a), 71);

    // full 1/32 cycle forward: every table entry, wrap back to home
    for (int k = 0; k < 128; k++) begin
      do_step(1'b1, 5, 1'b1);
      chk_pos("R5");
    end
    chk("R4", "home_n", int'(home_n), 0);

    // every resolution code forward then backward
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 3; k++) begin
        do_step(1'b1, m, 1'b1);
        chk_pos("R3");
      end
      do_step(1'b0, m, 1'b1);
      chk_pos("R2");
    end

    // reverse full steps across the zero boundary
    for (int k = 0; k < 6; k++) begin
      do_step(1'b0, 0, 1'b1);
      chk_pos("R4");
    end

    // STEP held high moves only once
    @(negedge clk);
    dir_i = 1'b1; mode_i = 3'd5; step_i = 1'b1;
    repeat (6) @(negedge clk);
    m_idx = (m_idx + 1) % 128;
    chk_pos("R1");
    step_i = 1'b0;
    @(negedge clk);
    chk_pos("R1");

    // mode change without a step keeps the position
    mode_i = 3'd0;
    repeat (3) @(negedge clk);
    chk_pos("R10");
    do_step(1'b1, 0, 1'b1);
    chk_pos("R10");

    // disabled: zero targets, steps ignored
    en_n = 1'b1;
    @(negedge clk);
    chk_off("R6");
    do_step(1'b1, 5, 1'b0);
    chk_off("R6");
    en_n = 1'b0;
    @(negedge clk);
    chk_pos("R6");

    // sleep: zero targets, steps ignored, then wake lockout boundary
    pwr_up = 1'b0;
    @(negedge clk);
    chk_off("R9");
    do_step(1'b1, 5, 1'b0);
    chk_off("R9");
    pwr_up = 1'b1;
    wake_probe(WAKE, 1'b0);
    wake_probe(WAKE + 1, 1'b1);

    // reset in mid-run returns home
    repeat (WAKE + 2) @(negedge clk);
    do_step(1'b1, 2, 1'b1);
    chk("R8", "home_n", int'(home_n), (m_idx == HOME) ? 0 : 1);
    rst_n = 1'b0;
    m_idx = HOME;
    @(negedge clk);
    chk_off("R7");
    chk("R7", "home_n", int'(home_n), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pos("R7");

    finish_run();
  end
endmodule